// File: doc/BRIEF.md
# Gated and Compare Mode Timer

This block is a 16-bit up-counting timer run from a prescaled system clock and programmed through a small byte-wide register bus. In compare mode it counts up from a loaded start value. When the count reaches the programmed compare value it raises an interrupt and toggles its output pin. It then keeps counting and wraps through zero. In gated mode it counts only while an external timer input, passed through a two-flop synchronizer, sits at the level chosen by a polarity bit. On reaching the reload value it restarts at 0001h. It raises an interrupt on each reload and also when the input leaves its active level.

Software disables the timer first. It then programs the mode, the prescale, the polarity and the initial output level, and loads the count and reload bytes. Setting the enable bit last starts the timer. While the timer is disabled the output pin shows the programmed initial level, so the first toggle starts from a known state. The count bytes stay readable at any time.

Top module: `gate_cmp_timer`

## Requirements
- R1: After reset every register reads 0, and `tmr_out` and `irq` are 0.
- R2: The write address selects the register: 0 is control, 1 is count high byte, 2 is count low byte, 3 is reload high byte, 4 is reload low byte. Reads through `rd_addr` are combinational. Unused addresses and control bit 3 read 0. The control fields are: bit 7 enable, bit 6 mode (1 gated, 0 compare), bit 5 polarity (1 active high, 0 active low), bit 4 initial output level, and bits 2:0 prescale `p`.
- R3: While enabled, the count advances once every 2^p enabled cycles. The first advance happens at the 2^p-th rising edge after the edge that sets enable. The prescaler clears while the timer is disabled, and a disabled count holds.
- R4: In compare mode, when a step makes the count equal the compare value, `irq` pulses and `tmr_out` toggles. The count keeps incrementing and wraps from FFFFh to 0000h.
- R5: In gated mode, the count steps only while the synchronized input equals the polarity level. A change at `tmr_in` affects counting from the third rising edge after the change.
- R6: In gated mode, a step taken when the count equals the reload value sets the count to 0001h, pulses `irq` and toggles `tmr_out`.
- R7: When enabled in gated mode, the synchronized input moving from active to inactive pulses `irq`. The pulse is visible after the third rising edge following the input change. Compare mode gives no such pulse.
- R8: While the timer is disabled, `tmr_out` equals the initial-level bit. Toggles start from that level.
- R9: A write to either count byte in the cycle of a step wins. The written byte takes the bus value, the other byte holds, and that step and its interrupt are dropped.
- R10: `irq` is a registered pulse lasting one cycle per event cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 8 | Read data byte (combinational) |
| tmr_in | input | 1 | Asynchronous timer gate input |
| tmr_out | output | 1 | Timer output pin |
| irq | output | 1 | Interrupt pulse |

## Verification
Two things can land in the same cycle. One is a counter step that would hit the compare value; the other is a bus write to a count byte. The bench provokes this by writing the low count byte exactly on the edge where the compare match would occur. It then judges that `irq` stays low, that the low byte holds the written value and that the high byte keeps its pre-step value. In the same spirit, a gated reload and an input deassertion are driven on adjacent cycles. The bench checks that each produces its own pulse on the edge the requirements predict.

// File: rtl/gct_pkg.sv
package gct_pkg;
    localparam int DW  = 8;
    localparam int CW  = 2 * DW;
    localparam int PSW = 3;
    localparam int AW  = 3;

    localparam logic [AW-1:0] A_CTRL = 3'd0;
    localparam logic [AW-1:0] A_CNTH = 3'd1;
    localparam logic [AW-1:0] A_CNTL = 3'd2;
    localparam logic [AW-1:0] A_RLDH = 3'd3;
    localparam logic [AW-1:0] A_RLDL = 3'd4;

    typedef struct packed {
        logic           en;
        logic           gated;
        logic           pol;
        logic           init;
        logic           rsvd;
        logic [PSW-1:0] ps;
    } ctrl_t;

    typedef struct packed {
        ctrl_t          ctrl;
        logic [CW-1:0]  cnt;
        logic [CW-1:0]  rld;
        logic           out;
        logic           irq;
        logic           in_prev;
    } st_t;
endpackage

// File: rtl/gct_sync.sv
module gct_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sy_t;

    sy_t sy_d, sy_q;

    always_comb begin
        sy_d.s1 = din;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign dout = sy_q.s2;
endmodule

// File: rtl/gct_prescale.sv
module gct_prescale #(
    parameter int PSW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic [PSW-1:0] ps,
    output logic           tick
);
    localparam int PW = (1 << PSW) - 1;

    logic [PW-1:0] pcnt_d, pcnt_q, mask;

    always_comb begin
        mask   = PW'((32'd1 << ps) - 32'd1);
        tick   = en && ((pcnt_q & mask) == mask);
        pcnt_d = en ? pcnt_q + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pcnt_q <= '0;
        else        pcnt_q <= pcnt_d;
    end

    // R3: with division above one, ticks never fall on adjacent cycles
    p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ps != '0) |=> (!tick || ps != $past(ps)));
endmodule

// File: rtl/gct_core.sv
module gct_core
    import gct_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          tick,
    input  logic          in_s,
    output ctrl_t         ctrl,
    output logic          tmr_out,
    output logic          irq
);
    st_t st_d, st_q;
    logic          cnt_wr, act, act_prev, step, hit, deassert;
    logic [CW-1:0] cnt_inc;

    always_comb begin
        st_d          = st_q;
        st_d.irq      = 1'b0;
        st_d.in_prev  = in_s;
        cnt_wr   = wr_en && (wr_addr == A_CNTH || wr_addr == A_CNTL);
        act      = (in_s == st_q.ctrl.pol);
        act_prev = (st_q.in_prev == st_q.ctrl.pol);
        step     = st_q.ctrl.en && tick && (!st_q.ctrl.gated || act) && !cnt_wr;
        cnt_inc  = st_q.cnt + 1'b1;
        hit      = st_q.ctrl.gated ? (st_q.cnt == st_q.rld) : (cnt_inc == st_q.rld);
        deassert = st_q.ctrl.en && st_q.ctrl.gated && act_prev && !act;

        if (step) begin
            st_d.cnt = (st_q.ctrl.gated && hit) ? CW'(1) : cnt_inc;
            if (hit) begin
                st_d.irq = 1'b1;
                st_d.out = ~st_q.out;
            end
        end
        if (deassert) st_d.irq = 1'b1;

        if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    st_d.ctrl      = ctrl_t'(wr_data);
                    st_d.ctrl.rsvd = 1'b0;
                end
                A_CNTH:  st_d.cnt[CW-1:DW] = wr_data;
                A_CNTL:  st_d.cnt[DW-1:0]  = wr_data;
                A_RLDH:  st_d.rld[CW-1:DW] = wr_data;
                A_RLDL:  st_d.rld[DW-1:0]  = wr_data;
                default: ;
            endcase
        end
        if (!st_d.ctrl.en) st_d.out = st_d.ctrl.init;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (rd_addr)
            A_CTRL:  rd_data = st_q.ctrl;
            A_CNTH:  rd_data = st_q.cnt[CW-1:DW];
            A_CNTL:  rd_data = st_q.cnt[DW-1:0];
            A_RLDH:  rd_data = st_q.rld[CW-1:DW];
            A_RLDL:  rd_data = st_q.rld[DW-1:0];
            default: rd_data = '0;
        endcase
    end

    assign ctrl    = st_q.ctrl;
    assign tmr_out = st_q.out;
    assign irq     = st_q.irq;

    // R4: while enabled, the output only moves together with an interrupt
    p_out_with_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.en && $past(st_q.ctrl.en) && st_q.out != $past(st_q.out)) |-> st_q.irq);

    // R5: an inactive gate freezes the count
    p_hold_inactive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.en && st_q.ctrl.gated && !act && !cnt_wr) |=> $stable(st_q.cnt));

    // R3: a disabled timer holds its count
    p_hold_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl.en && !cnt_wr) |=> $stable(st_q.cnt));

    // R6: gated counting either holds, steps by one or restarts at 0001h
    p_gated_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.en && st_q.ctrl.gated && !cnt_wr) |=>
        (st_q.cnt == $past(st_q.cnt) || st_q.cnt == $past(st_q.cnt) + 1'b1 || st_q.cnt == CW'(1)));

    // R9: a low-byte write lands regardless of a coincident step
    p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_CNTL) |=> st_q.cnt[DW-1:0] == $past(wr_data));
endmodule

// File: rtl/gate_cmp_timer.sv
module gate_cmp_timer
    import gct_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          tmr_in,
    output logic          tmr_out,
    output logic          irq
);
    logic  in_s, tick;
    ctrl_t ctrl;

    gct_sync u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (tmr_in),
        .dout (in_s)
    );

    gct_prescale #(.PSW(PSW)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (ctrl.en),
        .ps   (ctrl.ps),
        .tick (tick)
    );

    gct_core u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data),
        .tick   (tick),
        .in_s   (in_s),
        .ctrl   (ctrl),
        .tmr_out(tmr_out),
        .irq    (irq)
    );
endmodule

// File: tb/gate_cmp_timer_bench.sv
`timescale 1ns/1ps
module gate_cmp_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       tmr_in = 1'b0;
    logic       tmr_out, irq;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    gate_cmp_timer u_gate_cmp_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tmr_in(tmr_in), .tmr_out(tmr_out), .irq(irq)
    );

    // control byte: en[7] gated[6] pol[5] init[4] ps[2:0]
    function automatic logic [7:0] ctl(bit en, bit g, bit pol, bit init, int ps);
        return {en, g, pol, init, 1'b0, 3'(ps)};
    endfunction

    function automatic logic [15:0] exp_cmp(logic [15:0] s, int k, int p);
        return s + 16'(k >> p);
    endfunction

    function automatic logic [15:0] exp_gate(logic [15:0] s, int k, bit lvl, bit pol);
        return (lvl == pol) ? s + 16'(k) : s;
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic bus_wr(logic [2:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        rd_addr = a; #1; d = rd_data;
    endtask

    task automatic rd_cnt(output logic [15:0] c);
        logic [7:0] h, l;
        rd(3'd1, h); rd(3'd2, l);
        c = {h, l};
    endtask

    task automatic load(logic [15:0] c, logic [15:0] r);
        bus_wr(3'd1, c[15:8]); bus_wr(3'd2, c[7:0]);
        bus_wr(3'd3, r[15:8]); bus_wr(3'd4, r[7:0]);
    endtask

    // enable for exactly k edges, then disable with same settings
    task automatic run_k(logic [7:0] c, int k);
        bus_wr(3'd0, c | 8'h80);
        repeat (k - 1) @(posedge clk);
        #1;
        bus_wr(3'd0, c & 8'h7F);
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] c, s;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), b); chk("R1 reg", {24'd0, b}, 32'd0);
        end
        chk("R1 out", {31'd0, tmr_out}, 0);
        chk("R1 irq", {31'd0, irq}, 0);

        // R2 map and reserved bit
        bus_wr(3'd0, 8'h7F); rd(3'd0, b); chk("R2 ctrl", {24'd0, b}, 32'h77);
        load(16'hA5C3, 16'h1E2D);
        rd_cnt(c); chk("R2 cnt", {16'd0, c}, 32'hA5C3);
        rd(3'd3, b); chk("R2 rldh", {24'd0, b}, 32'h1E);
        rd(3'd4, b); chk("R2 rldl", {24'd0, b}, 32'h2D);
        rd(3'd6, b); chk("R2 unused", {24'd0, b}, 0);
        // R8 idle output follows init level
        chk("R8 idle out", {31'd0, tmr_out}, 1);
        bus_wr(3'd0, ctl(0, 0, 0, 0, 0));
        chk("R8 idle out0", {31'd0, tmr_out}, 0);

        // R3 random compare counting with prescale
        for (int i = 0; i < 20; i++) begin
            int p = $urandom_range(0, 4);
            int k = $urandom_range(1, 120);
            s = 16'($urandom);
            load(s, s - 16'd1);
            run_k(ctl(0, 0, 0, 0, p), k);
            rd_cnt(c); chk("R3 prescaled count", {16'd0, c}, {16'd0, exp_cmp(s, k, p)});
        end

        // R3 prescaler clears on disable
        load(16'h0100, 16'h0000);
        run_k(ctl(0, 0, 0, 0, 2), 3);
        run_k(ctl(0, 0, 0, 0, 2), 3);
        rd_cnt(c); chk("R3 prescaler clear", {16'd0, c}, 32'h0100);

        // R4 wrap FFFFh to 0000h
        load(16'hFFFE, 16'h8000);
        run_k(ctl(0, 0, 0, 0, 0), 4);
        rd_cnt(c); chk("R4 wrap", {16'd0, c}, 32'h0002);

        // R4 / R10 compare interrupt timing and toggle
        for (int i = 0; i < 6; i++) begin
            int p = $urandom_range(0, 2);
            int m = $urandom_range(1, 6);
            bit ini = 1'($urandom);
            s = 16'($urandom);
            bus_wr(3'd0, ctl(0, 0, 0, ini, p));
            load(s, s + 16'(m));
            bus_wr(3'd0, ctl(1, 0, 0, ini, p));
            for (int k = 1; k <= (m << p) + 1; k++) begin
                @(posedge clk); #1;
                chk("R4 irq", {31'd0, irq}, {31'd0, k == (m << p)});
                chk("R10 out", {31'd0, tmr_out}, {31'd0, (k >= (m << p)) ? ~ini : ini});
            end
            bus_wr(3'd0, ctl(0, 0, 0, ini, p));
            chk("R8 out restored", {31'd0, tmr_out}, {31'd0, ini});
        end

        // R5 random gated counting
        for (int i = 0; i < 20; i++) begin
            bit pol = 1'($urandom);
            bit lvl = 1'($urandom);
            int k = $urandom_range(1, 40);
            s = 16'($urandom_range(0, 16'h7FFF));
            tmr_in = lvl;
            load(s, 16'hFFFF);
            repeat (4) @(posedge clk);
            #1;
            run_k(ctl(0, 1, pol, 0, 0), k);
            rd_cnt(c); chk("R5 gated count", {16'd0, c}, {16'd0, exp_gate(s, k, lvl, pol)});
        end

        // R5 gate change latency; R7 deassert interrupt
        tmr_in = 1'b1;
        load(16'h0000, 16'hFFFF);
        repeat (4) @(posedge clk);
        #1;
        bus_wr(3'd0, ctl(1, 1, 1, 0, 0));
        repeat (4) @(posedge clk);
        #1 tmr_in = 1'b0;
        rd_cnt(c); s = c;
        @(posedge clk); @(posedge clk); #1;
        rd_cnt(c); chk("R5 sync latency", {16'd0, c}, {16'd0, s + 16'd2});
        chk("R7 no early irq", {31'd0, irq}, 0);
        @(posedge clk); #1;
        chk("R7 deassert irq", {31'd0, irq}, 1);
        rd_cnt(c); chk("R5 frozen", {16'd0, c}, {16'd0, s + 16'd2});
        @(posedge clk); #1;
        chk("R10 pulse ends", {31'd0, irq}, 0);
        bus_wr(3'd0, ctl(0, 1, 1, 0, 0));

        // R7 compare mode ignores deassertion
        tmr_in = 1'b1;
        load(16'h0000, 16'hFFF0);
        bus_wr(3'd0, ctl(1, 0, 1, 0, 0));
        repeat (3) @(posedge clk);
        #1 tmr_in = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(posedge clk); #1;
            chk("R7 compare no irq", {31'd0, irq}, 0);
        end
        bus_wr(3'd0, ctl(0, 0, 1, 0, 0));

        // R6 gated reload to 0001h, active low, init high
        tmr_in = 1'b0;
        bus_wr(3'd0, ctl(0, 1, 0, 1, 0));
        load(16'h000E, 16'h0010);
        repeat (3) @(posedge clk);
        #1;
        bus_wr(3'd0, ctl(1, 1, 0, 1, 0));
        for (int k = 1; k <= 4; k++) begin
            @(posedge clk); #1;
            chk("R6 irq", {31'd0, irq}, {31'd0, k == 3});
            chk("R6 out", {31'd0, tmr_out}, {31'd0, k < 3});
            if (k == 3) begin
                rd_cnt(c); chk("R6 restart", {16'd0, c}, 32'h0001);
            end
        end
        bus_wr(3'd0, ctl(0, 1, 0, 1, 0));
        rd_cnt(c); chk("R6 continue", {16'd0, c}, 32'h0003);
        chk("R8 out init", {31'd0, tmr_out}, 1);

        // R6/R7 reload then deassertion on adjacent cycles
        tmr_in = 1'b1;
        load(16'h0004, 16'h0005);
        repeat (3) @(posedge clk);
        #1;
        bus_wr(3'd0, ctl(1, 1, 1, 0, 0));   // edge E: E+1 cnt 5, E+2 reload
        tmr_in = 1'b0;                      // gate inactive from E+3, deassert seen at E+3
        @(posedge clk); #1;
        chk("R6 adj none", {31'd0, irq}, 0);
        @(posedge clk); #1;
        chk("R6 adj reload", {31'd0, irq}, 1);
        @(posedge clk); #1;
        chk("R7 adj deassert", {31'd0, irq}, 1);
        @(posedge clk); #1;
        chk("R10 adj end", {31'd0, irq}, 0);
        bus_wr(3'd0, ctl(0, 1, 1, 0, 0));
        rd_cnt(c); chk("R6 adj count", {16'd0, c}, 32'h0001);

        // R9 count write collides with compare match
        load(16'h1200, 16'h1203);
        bus_wr(3'd0, ctl(1, 0, 0, 0, 0));
        @(posedge clk); #1;
        @(posedge clk); #1;
        rd_addr = 3'd2;
        bus_wr(3'd2, 8'h50);
        chk("R9 irq dropped", {31'd0, irq}, 0);
        #1 chk("R9 low byte", {24'd0, rd_data}, 32'h50);
        bus_wr(3'd0, ctl(0, 0, 0, 0, 0));
        rd_cnt(c); chk("R9 high held", {16'd0, c}, 32'h1251);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule